// File: doc/BRIEF.md
# Receiver-Aligned Synchronous Bit-Serial Transmitter

This block is a bit-serial synchronous transmitter. It shifts out data characters, sync characters and a CRC-16 check word. One bit moves for each pulse of a bit-enable strobe, and the block runs on a single clock. While the transmitter is disabled, the line idles at mark (1) or, when break is requested, at space (0). If the transmitter is disabled in the middle of a data or sync character, that character is completed before the line idles. If it is disabled in the middle of the CRC, the remaining CRC slots are replaced by sync-pattern bits.

The block has a second way to start, locked to a companion receiver. With the receiver-lock mode and the poll-arm input both set, an enabled transmitter keeps idling while the receiver hunts. It goes active on the first receiver character-boundary strobe after the receiver leaves hunt. From then on it runs on its own, and its character boundaries line up with the receiver's. This kind of start is accepted only for 6-bit, 8-bit and 16-bit sync lengths. Data characters are 6 bits long with a 6-bit sync and 8 bits long otherwise.

Top module: `rxs_aligned_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `txd` is 1 and `tx_active`, `tx_bnd` and `data_ack` are 0.
- R2: While the transmitter is inactive, `txd` equals the inverse of `brk_en`, one clock after any change of `brk_en`. Bit-enable pulses do not activate the transmitter while `tx_en` is 0.
- R3: With `loop_mode` = 0 and `tx_en` = 1, the transmitter starts on the next `bit_en`. Data characters go out LSB first, one bit per `bit_en`. They are 6 bits long for `sync_mode` = 0 and 8 bits long otherwise. `data_ack` pulses for one clock when a character is taken from `data_in`. `tx_bnd` pulses for one clock with the last bit of every character.
- R4: When no data is offered and no CRC is pending, sync characters taken LSB first from `sync_word` are sent. They are 6 bits long for `sync_mode` = 0, 8 bits for 1 and 16 bits for 2.
- R5: When `crc_en` is 1 as a data character is taken, a CRC is sent once data runs out. The CRC covers the data bits in sending order, uses the polynomial 0x8005 and starts from 0. It goes out as 16 bits, MSB first, and is followed by sync characters. The CRC register clears when the CRC is loaded.
- R6: If `tx_en` drops during a data or sync character, the rest of that character is sent and the line then goes idle with `tx_active` = 0.
- R7: If `tx_en` is 0 at a `bit_en` during a CRC, that slot and every later slot k (k = 0..15) carry `sync_word[k]`. After slot 15 the line idles.
- R8: With `loop_mode` = 1, the transmitter starts only when `tx_en` and `go_poll` are set, `rx_hunt` has gone from 1 to 0, and then `rx_char_bnd` comes with `bit_en`. The first bit goes out at that edge. Later characters follow back to back without further strobes.
- R9: With `loop_mode` = 1, a boundary strobe while `rx_hunt` is 1, or any strobe while `go_poll` is 0, leaves the line idle.
- R10: `sync_mode` = 3 behaves as the 8-bit setting when `loop_mode` = 0. With `loop_mode` = 1 it never activates the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock strobe per serial bit time |
| tx_en | input | 1 | Transmitter enable |
| brk_en | input | 1 | Idle at space instead of mark |
| loop_mode | input | 1 | Start locked to the receiver |
| go_poll | input | 1 | Arm the receiver-locked start |
| sync_mode | input | 2 | 0: 6-bit sync, 1: 8-bit, 2: 16-bit, 3: reserved |
| sync_word | input | 16 | Sync pattern, bit 0 sent first |
| crc_en | input | 1 | Append CRC after the current data run |
| data_valid | input | 1 | A data character is offered |
| data_in | input | 8 | Data character, bit 0 sent first |
| rx_hunt | input | 1 | Receiver is hunting for sync |
| rx_char_bnd | input | 1 | Receiver character boundary strobe |
| data_ack | output | 1 | Data character taken |
| txd | output | 1 | Serial output |
| tx_bnd | output | 1 | Last bit of a character is on `txd` |
| tx_active | output | 1 | Transmitter is sending characters |

## Verification
Every serial result is registered at the clock edge that carries `bit_en`: the new `txd` bit, the `tx_bnd` and `data_ack` pulses, and any change of `tx_active`. All of them are due one clock after the strobe. The bench therefore raises `bit_en` on a falling edge and samples the outputs on the following falling edge. At that point the single-clock pulses are still high. The idle level follows `brk_en` one clock later in the same way. Control changes such as dropping `tx_en` or `rx_hunt` are applied between bit strobes, so each one is seen at a known strobe.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int DATA_W = 8;
    localparam int SYNC_W = 16;
    localparam int CRC_W  = 16;
    localparam int CNT_W  = $clog2(SYNC_W + 1);
    localparam int IDX_W  = $clog2(SYNC_W);

    typedef enum logic [1:0] {
        SM_SYNC6  = 2'd0,
        SM_SYNC8  = 2'd1,
        SM_SYNC16 = 2'd2,
        SM_RSVD   = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        CK_DATA,
        CK_SYNC,
        CK_CRC,
        CK_FILL
    } chr_kind_e;

    typedef struct packed {
        chr_kind_e         kind;
        logic [CNT_W-1:0]  len;
        logic [SYNC_W-1:0] bits;
    } chr_t;

    function automatic logic [CNT_W-1:0] sync_len(sync_mode_e m);
        case (m)
            SM_SYNC6:  return CNT_W'(6);
            SM_SYNC16: return CNT_W'(16);
            default:   return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] data_len(sync_mode_e m);
        return (m == SM_SYNC6) ? CNT_W'(6) : CNT_W'(DATA_W);
    endfunction

    function automatic logic [CRC_W-1:0] crc_bit(logic [CRC_W-1:0] c, logic b,
                                                 logic [CRC_W-1:0] poly);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/rxs_crc16.sv
module rxs_crc16
    import rxs_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              absorb,
    input  logic              clear,
    input  logic [DATA_W-1:0] chr,
    input  logic [CNT_W-1:0]  nbits,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] acc;

    always_comb begin
        acc = crc;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) acc = crc_bit(acc, chr[i], POLY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         crc <= '0;
        else if (clear)  crc <= '0;
        else if (absorb) crc <= acc;
    end

endmodule

// File: rtl/rxs_char_sel.sv
module rxs_char_sel
    import rxs_pkg::*;
(
    input  sync_mode_e        mode,
    input  logic              data_valid,
    input  logic              crc_pend,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [CRC_W-1:0]  crc,
    output chr_t              nxt,
    output logic              take_data,
    output logic              take_crc
);

    logic [CNT_W-1:0]  dlen;
    logic [SYNC_W-1:0] dbits;
    logic [SYNC_W-1:0] cbits;

    always_comb begin
        dlen      = data_len(mode);
        take_data = data_valid;
        take_crc  = !data_valid && crc_pend;

        dbits = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < dlen) dbits[i] = data_in[i];
        end

        cbits = '0;
        for (int k = 0; k < CRC_W; k++) begin
            cbits[k] = crc[CRC_W-1-k];
        end

        if (take_data) begin
            nxt.kind = CK_DATA;
            nxt.len  = dlen;
            nxt.bits = dbits;
        end else if (take_crc) begin
            nxt.kind = CK_CRC;
            nxt.len  = CNT_W'(CRC_W);
            nxt.bits = cbits;
        end else begin
            nxt.kind = CK_SYNC;
            nxt.len  = sync_len(mode);
            nxt.bits = sync_word;
        end
    end

endmodule

// File: rtl/rxs_arm.sv
module rxs_arm (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    input  logic rx_hunt,
    input  logic bit_en,
    input  logic rx_char_bnd,
    output logic fire
);

    logic hunt_q;
    logic left_hunt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hunt_q    <= 1'b0;
            left_hunt <= 1'b0;
        end else begin
            hunt_q <= rx_hunt;
            if (!waiting || rx_hunt) left_hunt <= 1'b0;
            else if (hunt_q)         left_hunt <= 1'b1;
        end
    end

    assign fire = waiting && left_hunt && bit_en && rx_char_bnd;

endmodule

// File: rtl/rxs_aligned_tx.sv
module rxs_aligned_tx
    import rxs_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic              brk_en,
    input  logic              loop_mode,
    input  logic              go_poll,
    input  logic [1:0]        sync_mode,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic              crc_en,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rx_hunt,
    input  logic              rx_char_bnd,
    output logic              data_ack,
    output logic              txd,
    output logic              tx_bnd,
    output logic              tx_active
);

    sync_mode_e        mode;
    chr_t              nxt;
    logic              take_data, take_crc;
    logic [CRC_W-1:0]  crc;

    logic              active_q, txd_q, bnd_q, ack_q, crc_pend;
    chr_kind_e         kind_q;
    logic [CNT_W-1:0]  len_q, pos_q;
    logic [SYNC_W-1:0] bits_q;

    logic              waiting, arm_fire, start_ok, pos_last, load_fire, cut;
    logic [IDX_W-1:0]  nxt_idx;
    logic [SYNC_W-1:0] eff_bits;

    assign mode = sync_mode_e'(sync_mode);

    rxs_char_sel u_sel (
        .mode       (mode),
        .data_valid (data_valid),
        .crc_pend   (crc_pend),
        .data_in    (data_in),
        .sync_word  (sync_word),
        .crc        (crc),
        .nxt        (nxt),
        .take_data  (take_data),
        .take_crc   (take_crc)
    );

    assign waiting = !active_q && tx_en && loop_mode && go_poll && (mode != SM_RSVD);

    rxs_arm u_arm (
        .clk         (clk),
        .rst         (rst),
        .waiting     (waiting),
        .rx_hunt     (rx_hunt),
        .bit_en      (bit_en),
        .rx_char_bnd (rx_char_bnd),
        .fire        (arm_fire)
    );

    assign start_ok  = loop_mode ? arm_fire : (tx_en && bit_en);
    assign pos_last  = (pos_q == len_q - 1'b1);
    assign load_fire = (!active_q && start_ok) ||
                       (active_q && bit_en && pos_last && tx_en);
    assign cut       = (kind_q == CK_CRC) && !tx_en;
    assign eff_bits  = cut ? sync_word : bits_q;
    assign nxt_idx   = pos_q[IDX_W-1:0] + 1'b1;

    rxs_crc16 #(.POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst    (rst),
        .absorb (load_fire && take_data),
        .clear  (load_fire && take_crc),
        .chr    (data_in),
        .nbits  (data_len(mode)),
        .crc    (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            txd_q    <= 1'b1;
            bnd_q    <= 1'b0;
            ack_q    <= 1'b0;
            crc_pend <= 1'b0;
            kind_q   <= CK_SYNC;
            len_q    <= '0;
            pos_q    <= '0;
            bits_q   <= '0;
        end else begin
            bnd_q <= 1'b0;
            ack_q <= 1'b0;
            if (load_fire) begin
                active_q <= 1'b1;
                kind_q   <= nxt.kind;
                len_q    <= nxt.len;
                bits_q   <= nxt.bits;
                pos_q    <= '0;
                txd_q    <= nxt.bits[0];
                ack_q    <= take_data;
                if (take_data)     crc_pend <= crc_pend | crc_en;
                else if (take_crc) crc_pend <= 1'b0;
            end else if (!active_q) begin
                txd_q <= !brk_en;
            end else if (bit_en) begin
                if (pos_last) begin
                    active_q <= 1'b0;
                    txd_q    <= !brk_en;
                end else begin
                    if (cut) begin
                        bits_q <= sync_word;
                        kind_q <= CK_FILL;
                    end
                    pos_q <= pos_q + 1'b1;
                    txd_q <= eff_bits[nxt_idx];
                    bnd_q <= (pos_q + 1'b1 == len_q - 1'b1);
                end
            end
        end
    end

    assign txd       = txd_q;
    assign tx_bnd    = bnd_q;
    assign data_ack  = ack_q;
    assign tx_active = active_q;

endmodule

// File: rtl/rxs_aligned_tx_chk.sv
module rxs_aligned_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       brk_en,
    input logic       loop_mode,
    input logic       go_poll,
    input logic [1:0] sync_mode,
    input logic       data_valid,
    input logic       rx_char_bnd,
    input logic       data_ack,
    input logic       txd,
    input logic       tx_bnd,
    input logic       tx_active
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (txd && !tx_active && !tx_bnd));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !$past(rst)) |-> (txd == !$past(brk_en)));

    // R3
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active) && !$past(bit_en)) |-> $stable(txd));

    // R3
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        data_ack |-> ($past(bit_en) && $past(data_valid) && tx_active));

    // R3
    bnd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_bnd |-> ($past(bit_en) && tx_active));

    // R8
    locked_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_active) && $past(loop_mode)) |-> ($past(rx_char_bnd) && $past(go_poll)));

    // R10
    rsvd_refused_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_active) && $past(loop_mode)) |-> ($past(sync_mode) != 2'd3));

endmodule

bind rxs_aligned_tx rxs_aligned_tx_chk chk_i (.*);

// File: tb/rxs_aligned_tx_tb_top.sv
module rxs_aligned_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0, tx_en = 1'b0, brk_en = 1'b0, loop_mode = 1'b0, go_poll = 1'b0;
    logic [1:0]  sync_mode = 2'd1;
    logic [15:0] sync_word = 16'h0;
    logic        crc_en = 1'b0, data_valid = 1'b0;
    logic [7:0]  data_in = 8'h0;
    logic        rx_hunt = 1'b0, rx_char_bnd = 1'b0;
    logic        data_ack, txd, tx_bnd, tx_active;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rxs_aligned_tx dut_i (.*);

    // mode, sync pattern, first data, second data, crc request
    localparam logic [34:0] VECS [0:4] = '{
        {2'd1, 16'h1234, 8'hA7, 8'h3C, 1'b1},
        {2'd0, 16'h002D, 8'h15, 8'h2A, 1'b1},
        {2'd2, 16'hF0E1, 8'h01, 8'hFE, 1'b0},
        {2'd1, 16'h7E7E, 8'hFF, 8'h00, 1'b1},
        {2'd3, 16'h0096, 8'h5A, 8'hC3, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; tx_en = 1'b0; brk_en = 1'b0; loop_mode = 1'b0;
        go_poll = 1'b0; crc_en = 1'b0; data_valid = 1'b0; rx_hunt = 1'b0; rx_char_bnd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input logic cb, output logic b, output logic bd, output logic ak);
        @(negedge clk);
        bit_en = 1'b1; rx_char_bnd = cb;
        @(negedge clk);
        bit_en = 1'b0; rx_char_bnd = 1'b0;
        b = txd; bd = tx_bnd; ak = data_ack;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d, int n);
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = d[i] ^ c[15];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0);
        end
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic b, bd, ak;
        logic [63:0] eb, ebd;
        logic [15:0] crc;

        // R1 reset state
        @(negedge clk);
        chk("R1 txd in reset", txd, 1);
        chk("R1 active in reset", tx_active, 0);
        do_reset();
        chk("R1 txd after reset", txd, 1);
        chk("R1 bnd/ack after reset", {tx_bnd, data_ack}, 0);

        // R2 idle level and no start while disabled
        brk_en = 1'b1;
        @(negedge clk);
        chk("R2 break idles at space", txd, 0);
        tick(1'b0, b, bd, ak);
        chk("R2 disabled ignores bit_en", {tx_active, b}, 2'b00);
        brk_en = 1'b0;
        @(negedge clk);
        chk("R2 mark idle", txd, 1);

        // R3 R4 R5 R10 table of transmit vectors
        for (int v = 0; v < 5; v++) begin
            logic [1:0] md; logic [15:0] sw; logic [7:0] d0, d1; logic ce;
            int dl, sl, n, acks, e_d, e_c, e_s, e_b, e_a;
            {md, sw, d0, d1, ce} = VECS[v];
            dl = (md == 2'd0) ? 6 : 8;
            sl = (md == 2'd0) ? 6 : (md == 2'd2) ? 16 : 8;
            do_reset();
            sync_mode = md; sync_word = sw; crc_en = ce;
            data_in = d0; data_valid = 1'b1; tx_en = 1'b1;
            n = 0; eb = '0; ebd = '0;
            for (int i = 0; i < dl; i++) eb[n++] = d0[i];
            ebd[n-1] = 1'b1;
            for (int i = 0; i < dl; i++) eb[n++] = d1[i];
            ebd[n-1] = 1'b1;
            crc = crc_upd(crc_upd(16'h0, d0, dl), d1, dl);
            if (ce) begin
                for (int k = 0; k < 16; k++) eb[n++] = crc[15-k];
                ebd[n-1] = 1'b1;
            end
            for (int i = 0; i < sl; i++) eb[n++] = sw[i];
            ebd[n-1] = 1'b1;
            acks = 0; e_d = 0; e_c = 0; e_s = 0; e_b = 0; e_a = 0;
            for (int t = 0; t < n; t++) begin
                tick(1'b0, b, bd, ak);
                if (b !== eb[t]) begin
                    if (t < 2*dl) e_d++;
                    else if (ce && t < 2*dl + 16) e_c++;
                    else e_s++;
                end
                if (bd !== ebd[t]) e_b++;
                if (ak !== (t == 0 || t == dl)) e_a++;
                if (ak) begin
                    acks++;
                    if (acks == 1) data_in = d1;
                    else data_valid = 1'b0;
                end
            end
            chk($sformatf("R3 data bits vec%0d", v), e_d, 0);
            chk($sformatf("R3 boundary pulses vec%0d", v), e_b, 0);
            chk($sformatf("R3 data_ack vec%0d", v), e_a, 0);
            if (ce) chk($sformatf("R5 crc bits vec%0d", v), e_c, 0);
            chk($sformatf("R4 sync bits vec%0d (R10 when mode 3)", v), e_s, 0);
        end

        // R6 disable during a data character
        do_reset();
        sync_mode = 2'd1; data_in = 8'h96; data_valid = 1'b1; tx_en = 1'b1;
        begin
            int err = 0;
            for (int i = 0; i < 8; i++) begin
                tick(1'b0, b, bd, ak);
                if (ak) data_valid = 1'b0;
                if (b !== data_in[i]) err++;
                if (i == 2) tx_en = 1'b0;
            end
            chk("R6 data char completes", err, 0);
        end
        tick(1'b0, b, bd, ak);
        chk("R6 idle after data char", {tx_active, b}, 2'b01);

        // R6 disable during a 16-bit sync character
        do_reset();
        sync_mode = 2'd2; sync_word = 16'h3A5C; tx_en = 1'b1;
        begin
            int err = 0;
            for (int i = 0; i < 16; i++) begin
                tick(1'b0, b, bd, ak);
                if (b !== sync_word[i]) err++;
                if (i == 4) tx_en = 1'b0;
            end
            chk("R6 sync char completes", err, 0);
        end
        tick(1'b0, b, bd, ak);
        chk("R6 idle after sync char", {tx_active, b}, 2'b01);

        // R7 disable during CRC
        do_reset();
        sync_mode = 2'd1; sync_word = 16'hC3A9; crc_en = 1'b1;
        data_in = 8'h4D; data_valid = 1'b1; tx_en = 1'b1;
        crc = crc_upd(16'h0, 8'h4D, 8);
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, b, bd, ak);
            if (ak) data_valid = 1'b0;
        end
        begin
            int e_c = 0, e_f = 0;
            for (int k = 0; k < 16; k++) begin
                if (k == 5) tx_en = 1'b0;
                tick(1'b0, b, bd, ak);
                if (k < 5 && b !== crc[15-k]) e_c++;
                if (k >= 5 && b !== sync_word[k]) e_f++;
            end
            chk("R7 crc head before disable", e_c, 0);
            chk("R7 sync fill after disable", e_f, 0);
        end
        tick(1'b0, b, bd, ak);
        chk("R7 idle after fill", {tx_active, b}, 2'b01);

        // R8 R9 receiver-locked start
        do_reset();
        sync_mode = 2'd1; sync_word = 16'h00F0; rx_hunt = 1'b1;
        loop_mode = 1'b1; tx_en = 1'b1; go_poll = 1'b1;
        tick(1'b1, b, bd, ak);
        chk("R9 strobe while hunting ignored", {tx_active, b}, 2'b01);
        @(negedge clk); rx_hunt = 1'b0;
        @(negedge clk);
        tick(1'b0, b, bd, ak);
        chk("R8 waits for boundary strobe", {tx_active, b}, 2'b01);
        tick(1'b1, b, bd, ak);
        chk("R8 starts at boundary", {tx_active, b}, 2'b10);
        begin
            int err = 0;
            for (int i = 1; i < 8; i++) begin
                tick(1'b0, b, bd, ak);
                if (b !== sync_word[i]) err++;
            end
            chk("R8 locked sync char", err, 0);
            chk("R8 boundary on last bit", bd, 1);
        end
        tick(1'b0, b, bd, ak);
        chk("R8 next char follows unaided", {tx_active, b}, 2'b10);

        // R9 no start without go_poll
        do_reset();
        sync_mode = 2'd1; sync_word = 16'h0000; rx_hunt = 1'b1;
        loop_mode = 1'b1; tx_en = 1'b1;
        @(negedge clk); rx_hunt = 1'b0;
        @(negedge clk);
        tick(1'b1, b, bd, ak);
        chk("R9 no start without poll", {tx_active, b}, 2'b01);

        // R10 reserved sync length refused in locked mode
        do_reset();
        sync_mode = 2'd3; sync_word = 16'h0000; rx_hunt = 1'b1;
        loop_mode = 1'b1; tx_en = 1'b1; go_poll = 1'b1;
        @(negedge clk); rx_hunt = 1'b0;
        @(negedge clk);
        tick(1'b1, b, bd, ak);
        chk("R10 reserved mode refused", {tx_active, b}, 2'b01);

        report();
    end

endmodule